// File: doc/BRIEF.md
# Serial Port Register and Status Front End

This block is the register-side half of a serial port. A 32-bit register bus reads and writes a set of word-indexed registers. On the other side, a byte-wide character link carries data. Outgoing bytes leave on a valid/ready pair. Incoming bytes, or a line-break indication, arrive on a strobe and land in a single holding register. Software drains that register by reading it, and the read itself consumes the character.

Around this datapath the block keeps:
- control words;
- two sticky status words, which line-side event strobes set and software clears by writing ones;
- baud and timing shadow words, which only store and return what software writes;
- a test/status word that shows whether each direction is empty.

A single level interrupt combines receive-ready, transmit-ready and transmitter-empty under the enables held in control word 1. Writing control word 2 with its reset bit at zero returns the register file to its reset contents.

Bus addresses are byte offsets. The register is chosen by the word index, which is the offset shifted right by two. A read returns data combinationally in the same cycle. Any side effect of a read or a write takes place at the clock edge that ends the access.

Top module: `uart_regfront`

## Requirements
- R1: After reset, the registers read back as follows:
  - status 1 (word 0x25) reads 0x6040 (transmit-ready bit 13, RTS status bit 14, receiver idle bit 6);
  - status 2 (word 0x26) reads 0x4028 (transmit FIFO empty bit 14, DCD input bit 5, transmit complete bit 3);
  - test/status (word 0x2D) reads 0x0060 (receive-empty bit 5, transmit-empty bit 6);
  - control 1 (word 0x20) reads 0 and control 2 (word 0x21) reads 0x0001;
  - control 3 (word 0x22) reads 0x0700;
  - baud modulator (word 0x2A) reads 0 and baud count (word 0x2B) reads 4;
  - the receive word (word 0x00) reads 0x4000, which is the error flag in bit 14.
  - The irq output is low, tx_valid is low and rx_ready is high.
- R2: Writes to the following words store the low 16 bits of the write data:
  - control 1 (0x20), control 2 (0x21) and control 3 (0x22);
  - FIFO control (0x24);
  - the millisecond word (0x2C);
  - the baud modulator (0x2A).
- R2 (continued): Writes to the baud increment word (0x29) load the baud count, which reads back at 0x2B, while reads of 0x29 return 0. Writes to control 4 (0x23) and to test/status are ignored, and control 4 reads 0. Any undecoded word reads 0.
- R3: A byte on rx_valid is taken only while rx_ready is high. rx_ready is the inverse of receive-ready, which is status 1 bit 9. Taking a byte stores it in bits 7:0 of the holding register, sets status 1 bit 9 and status 2 bit 0, and clears test/status bit 5. A byte offered while the holding register is full is dropped and leaves the held value unchanged.
- R4: A receive-word read with the holding register full returns the held value with bit 15 set. It also clears status 1 bit 9 and status 2 bit 0 and sets test/status bit 5. A read with the holding register empty returns the stale value without bit 15 and changes nothing.
- R5: An rx_break strobe, accepted under the same rule as a byte, loads the holding register with 0x0800, which is the break flag in bit 11.
- R6: Status 1 bits 15, 12, 11, 10, 8, 7, 5 and 4 (mask 0x9DB0) are sticky:
  - the matching bit of stat1_evt sets them;
  - writing a one to them clears them;
  - every other bit of a status 1 write is ignored.
- R7: Status 2 bits 15, 13, 12, 11, 10, 8, 7, 6, 4, 2 and 1 (mask 0xBDD6) follow the same sticky set and write-one-to-clear rule through stat2_evt. Every other bit of a status 2 write is ignored.
- R8: A write to the transmit word (0x10) is accepted only when control 2 bit 2 (transmit enable) is set and no byte is pending.
  - From the next cycle, tx_valid is high and tx_data carries write data bits 7:0.
  - While the byte is pending, status 1 bit 13, status 2 bits 14 and 3, and test/status bit 6 read 0.
  - All of them return high in the cycle after tx_ready is seen with tx_valid high.
  - A rejected write changes nothing.
- R9: irq is high exactly when one of two conditions holds:
  - receive-ready is set together with control 1 bit 9; or
  - control 1 bit 6 (transmitter-empty enable) is set, and either transmit-ready with control 1 bit 13 is set or test/status bit 6 is set.
  - When control 1 bit 6 is clear, transmit-ready contributes nothing.
- R10: A write to control 2 with bit 0 clear restores every register to its R1 value, drops any pending or held byte, and then stores the written value with bit 0 forced to 1. FIFO control and the millisecond word keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset; bits above 1 give the word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational while bus_sel is high |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Transmit byte pending |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Link takes the transmit byte |
| rx_valid | input | 1 | Incoming byte strobe |
| rx_data | input | 8 | Incoming byte |
| rx_break | input | 1 | Incoming line-break strobe |
| rx_ready | output | 1 | Holding register can take a byte |
| stat1_evt | input | 16 | Set strobes for sticky status 1 bits |
| stat2_evt | input | 16 | Set strobes for sticky status 2 bits |

## Verification
Read data is due in the same cycle as the read strobe, so the bench samples bus_rdata one time step after it drives a read, well before the clock edge. Every other effect needs exactly one clock edge: the consumption of a read, a register write, a byte or break taken from the link, a sticky event, a transmit acceptance or handshake, and a software reset. The bench drives each stimulus on a falling edge and looks for the effect only after the following rising edge, either by a later bus read or by sampling irq, tx_valid, tx_data and rx_ready at the next falling edge. irq is combinational from the registers, so it is checked in the same half-cycle as the state it depends on.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    localparam int REG_W  = 16;
    localparam int CHAR_W = 8;

    // word indices (byte offset >> 2)
    localparam logic [7:0] WI_RXD   = 8'h00;
    localparam logic [7:0] WI_TXD   = 8'h10;
    localparam logic [7:0] WI_CTL1  = 8'h20;
    localparam logic [7:0] WI_CTL2  = 8'h21;
    localparam logic [7:0] WI_CTL3  = 8'h22;
    localparam logic [7:0] WI_CTL4  = 8'h23;
    localparam logic [7:0] WI_FIFO  = 8'h24;
    localparam logic [7:0] WI_STS1  = 8'h25;
    localparam logic [7:0] WI_STS2  = 8'h26;
    localparam logic [7:0] WI_BINC  = 8'h29;
    localparam logic [7:0] WI_BMOD  = 8'h2A;
    localparam logic [7:0] WI_BCNT  = 8'h2B;
    localparam logic [7:0] WI_MSEC  = 8'h2C;
    localparam logic [7:0] WI_TEST  = 8'h2D;

    // control 1
    localparam int C1_TXEMPTY_IE = 6;
    localparam int C1_RXRDY_IE   = 9;
    localparam int C1_TXRDY_IE   = 13;
    // control 2
    localparam int C2_NRESET = 0;
    localparam int C2_TXEN   = 2;
    // status 1
    localparam int S1_RXRDY = 9;
    localparam int S1_TXRDY = 13;
    // status 2
    localparam int S2_RXDAT = 0;
    localparam int S2_TXDONE = 3;
    localparam int S2_TXFEMP = 14;
    // test/status
    localparam int T_RXEMPTY = 5;
    localparam int T_TXEMPTY = 6;
    // receive word
    localparam int RX_VALIDF = 15;

    localparam logic [REG_W-1:0] S1_STICKY = 16'h9DB0;
    localparam logic [REG_W-1:0] S2_STICKY = 16'hBDD6;
    localparam logic [REG_W-1:0] S1_INIT   = 16'h4040; // RTS status, receiver idle
    localparam logic [REG_W-1:0] S2_INIT   = 16'h0020; // DCD input
    localparam logic [REG_W-1:0] RX_INIT   = 16'h4000; // error flag
    localparam logic [REG_W-1:0] RX_BREAK  = 16'h0800; // break flag

    typedef struct packed {
        logic [REG_W-1:0]  ctl1;
        logic [REG_W-1:0]  ctl2;
        logic [REG_W-1:0]  ctl3;
        logic [REG_W-1:0]  fifo;
        logic [REG_W-1:0]  msec;
        logic [REG_W-1:0]  bmod;
        logic [REG_W-1:0]  bcnt;
        logic [REG_W-1:0]  sts1;   // stored bits; ready bits overlaid from flags
        logic [REG_W-1:0]  sts2;
        logic [REG_W-1:0]  rxbuf;
        logic              rx_full;
        logic              tx_pend;
        logic [CHAR_W-1:0] tx_byte;
    } rf_state_t;

    function automatic rf_state_t rf_init(input logic [REG_W-1:0] fifo_keep,
                                          input logic [REG_W-1:0] msec_keep);
        rf_state_t s;
        s.ctl1    = '0;
        s.ctl2    = 16'h0001;
        s.ctl3    = 16'h0700;
        s.fifo    = fifo_keep;
        s.msec    = msec_keep;
        s.bmod    = '0;
        s.bcnt    = 16'd4;
        s.sts1    = S1_INIT;
        s.sts2    = S2_INIT;
        s.rxbuf   = RX_INIT;
        s.rx_full = 1'b0;
        s.tx_pend = 1'b0;
        s.tx_byte = '0;
        return s;
    endfunction

endpackage

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
    import uart_rf_pkg::*;
(
    input  logic [REG_W-1:0] ctl1,
    input  logic             rx_ready_flag,
    input  logic             tx_ready_flag,
    input  logic             tx_empty_flag,
    output logic             irq
);
    logic rx_term;
    logic tx_term;

    always_comb begin
        rx_term = rx_ready_flag & ctl1[C1_RXRDY_IE];
        tx_term = (tx_ready_flag & ctl1[C1_TXRDY_IE]) | tx_empty_flag;
        irq     = rx_term | (ctl1[C1_TXEMPTY_IE] & tx_term);
    end
endmodule

// File: rtl/uart_rf_rdmux.sv
module uart_rf_rdmux
    import uart_rf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WIDX_W = 10
) (
    input  logic [WIDX_W-1:0] widx,
    input  rf_state_t         st,
    input  logic [REG_W-1:0]  sts1_view,
    input  logic [REG_W-1:0]  sts2_view,
    input  logic [REG_W-1:0]  test_view,
    output logic [DATA_W-1:0] rdata
);
    logic [REG_W-1:0] word;
    logic [REG_W-1:0] rx_word;

    always_comb begin
        rx_word            = st.rxbuf;
        rx_word[RX_VALIDF] = st.rxbuf[RX_VALIDF] | st.rx_full;
        case (widx)
            WIDX_W'(WI_RXD):  word = rx_word;
            WIDX_W'(WI_CTL1): word = st.ctl1;
            WIDX_W'(WI_CTL2): word = st.ctl2;
            WIDX_W'(WI_CTL3): word = st.ctl3;
            WIDX_W'(WI_FIFO): word = st.fifo;
            WIDX_W'(WI_STS1): word = sts1_view;
            WIDX_W'(WI_STS2): word = sts2_view;
            WIDX_W'(WI_BMOD): word = st.bmod;
            WIDX_W'(WI_BCNT): word = st.bcnt;
            WIDX_W'(WI_MSEC): word = st.msec;
            WIDX_W'(WI_TEST): word = test_view;
            default:          word = '0;
        endcase
        rdata = DATA_W'(word);
    end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_rf_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_break,
    output logic              rx_ready,
    input  logic [REG_W-1:0]  stat1_evt,
    input  logic [REG_W-1:0]  stat2_evt
);
    localparam int WIDX_W = ADDR_W - 2;

    rf_state_t         st_q, st_d;
    logic [WIDX_W-1:0] widx;
    logic [REG_W-1:0]  wlow;
    logic              wr_hit, rd_rx, soft_rst;
    logic [REG_W-1:0]  sts1_view, sts2_view, test_view;
    logic              unused_ok;

    assign widx      = bus_addr[ADDR_W-1:2];
    assign wlow      = bus_wdata[REG_W-1:0];
    assign wr_hit    = bus_sel & bus_wr;
    assign rd_rx     = bus_sel & ~bus_wr & (widx == WIDX_W'(WI_RXD));
    assign soft_rst  = wr_hit & (widx == WIDX_W'(WI_CTL2)) & ~wlow[C2_NRESET];
    assign unused_ok = ^{bus_addr[1:0], bus_wdata};

    // status views: ready/empty bits follow the buffer and transmit flags
    always_comb begin
        sts1_view            = st_q.sts1;
        sts1_view[S1_RXRDY]  = st_q.rx_full;
        sts1_view[S1_TXRDY]  = ~st_q.tx_pend;
        sts2_view            = st_q.sts2;
        sts2_view[S2_RXDAT]  = st_q.rx_full;
        sts2_view[S2_TXDONE] = ~st_q.tx_pend;
        sts2_view[S2_TXFEMP] = ~st_q.tx_pend;
        test_view            = '0;
        test_view[T_RXEMPTY] = ~st_q.rx_full;
        test_view[T_TXEMPTY] = ~st_q.tx_pend;
    end

    always_comb begin
        logic [REG_W-1:0] clr1, clr2;
        st_d = st_q;
        clr1 = '0;
        clr2 = '0;
        if (wr_hit && widx == WIDX_W'(WI_STS1)) clr1 = wlow & S1_STICKY;
        if (wr_hit && widx == WIDX_W'(WI_STS2)) clr2 = wlow & S2_STICKY;
        // events set, writes of one clear; a same-cycle event wins
        st_d.sts1 = (st_q.sts1 & ~clr1) | (stat1_evt & S1_STICKY);
        st_d.sts2 = (st_q.sts2 & ~clr2) | (stat2_evt & S2_STICKY);

        if (st_q.tx_pend && tx_ready) st_d.tx_pend = 1'b0;

        if ((rx_valid || rx_break) && !st_q.rx_full) begin
            st_d.rx_full = 1'b1;
            st_d.rxbuf   = rx_break ? RX_BREAK : REG_W'(rx_data);
        end
        if (rd_rx && st_q.rx_full) st_d.rx_full = 1'b0;

        if (wr_hit) begin
            case (widx)
                WIDX_W'(WI_TXD): begin
                    if (st_q.ctl2[C2_TXEN] && !st_q.tx_pend) begin
                        st_d.tx_pend = 1'b1;
                        st_d.tx_byte = bus_wdata[CHAR_W-1:0];
                    end
                end
                WIDX_W'(WI_CTL1): st_d.ctl1 = wlow;
                WIDX_W'(WI_CTL2): begin
                    if (!wlow[C2_NRESET]) st_d = rf_init(st_q.fifo, st_q.msec);
                    st_d.ctl2            = wlow;
                    st_d.ctl2[C2_NRESET] = 1'b1;
                end
                WIDX_W'(WI_CTL3): st_d.ctl3 = wlow;
                WIDX_W'(WI_FIFO): st_d.fifo = wlow;
                WIDX_W'(WI_BINC): st_d.bcnt = wlow;
                WIDX_W'(WI_BMOD): st_d.bmod = wlow;
                WIDX_W'(WI_MSEC): st_d.msec = wlow;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= rf_init('0, '0);
        else        st_q <= st_d;
    end

    assign tx_valid = st_q.tx_pend;
    assign tx_data  = st_q.tx_byte;
    assign rx_ready = ~st_q.rx_full;

    uart_rf_rdmux #(.DATA_W(DATA_W), .WIDX_W(WIDX_W)) i_rdmux (
        .widx      (widx),
        .st        (st_q),
        .sts1_view (sts1_view),
        .sts2_view (sts2_view),
        .test_view (test_view),
        .rdata     (bus_rdata)
    );

    uart_rf_irq i_irq (
        .ctl1          (st_q.ctl1),
        .rx_ready_flag (sts1_view[S1_RXRDY]),
        .tx_ready_flag (sts1_view[S1_TXRDY]),
        .tx_empty_flag (test_view[T_TXEMPTY]),
        .irq           (irq)
    );

    // R3: an offer against a full buffer leaves the held value alone
    a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready && !soft_rst) |=> $stable(st_q.rxbuf));
    // R4: consuming read empties the buffer
    a_r4_read_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && !rx_ready) |=> rx_ready);
    // R6: non-sticky status 1 bits never move except through reset
    a_r6_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> $stable(st_q.sts1 & ~S1_STICKY));
    // R8: pending byte held until taken
    a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !soft_rst) |=> (tx_valid && $stable(tx_data)));
    // R9: no interrupt source enabled means a quiet line
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctl1[C1_TXEMPTY_IE] && (rx_ready || !st_q.ctl1[C1_RXRDY_IE])) |-> !irq);
    // R10: software reset drops traffic and keeps the reset bit set
    a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (st_q.ctl2[C2_NRESET] && !tx_valid && rx_ready));
endmodule

// File: tb/test_uart_regfront.sv
module test_uart_regfront;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, tx_valid, tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0, rx_break = 1'b0, rx_ready;
    logic [7:0]  rx_data = '0;
    logic [15:0] stat1_evt = '0, stat2_evt = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    uart_regfront i_uart_regfront (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
        .rx_ready(rx_ready), .stat1_evt(stat1_evt), .stat2_evt(stat2_evt)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    // R1 reset image, then R2 storage / decode
    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h094, 32'h0, 32'h0000_6040},   // R1 status 1
        '{1'b0, 12'h098, 32'h0, 32'h0000_4028},   // R1 status 2
        '{1'b0, 12'h0B4, 32'h0, 32'h0000_0060},   // R1 test/status
        '{1'b0, 12'h080, 32'h0, 32'h0000_0000},   // R1 control 1
        '{1'b0, 12'h084, 32'h0, 32'h0000_0001},   // R1 control 2
        '{1'b0, 12'h088, 32'h0, 32'h0000_0700},   // R1 control 3
        '{1'b0, 12'h0A8, 32'h0, 32'h0000_0000},   // R1 modulator
        '{1'b0, 12'h0AC, 32'h0, 32'h0000_0004},   // R1 baud count
        '{1'b0, 12'h000, 32'h0, 32'h0000_4000},   // R1 receive word, empty
        '{1'b1, 12'h088, 32'hDEAD_1234, 32'h0},
        '{1'b0, 12'h088, 32'h0, 32'h0000_1234},   // R2 control 3
        '{1'b1, 12'h090, 32'hFFFF_A5A5, 32'h0},
        '{1'b0, 12'h090, 32'h0, 32'h0000_A5A5},   // R2 FIFO control
        '{1'b1, 12'h0B0, 32'h0001_03E8, 32'h0},
        '{1'b0, 12'h0B0, 32'h0, 32'h0000_03E8},   // R2 millisecond
        '{1'b1, 12'h0A8, 32'h0000_BEEF, 32'h0},
        '{1'b0, 12'h0A8, 32'h0, 32'h0000_BEEF},   // R2 modulator
        '{1'b1, 12'h0A4, 32'h0000_0123, 32'h0},
        '{1'b0, 12'h0AC, 32'h0, 32'h0000_0123},   // R2 increment loads count
        '{1'b0, 12'h0A4, 32'h0, 32'h0000_0000},   // R2 increment reads 0
        '{1'b1, 12'h08C, 32'h0000_FFFF, 32'h0},
        '{1'b0, 12'h08C, 32'h0, 32'h0000_0000},   // R2 control 4 reads 0
        '{1'b1, 12'h0B4, 32'h0000_0000, 32'h0},
        '{1'b0, 12'h0B4, 32'h0, 32'h0000_0060}    // R2 test/status write ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    task automatic send_rx(input logic brk, input logic [7:0] b);
        @(negedge clk);
        rx_valid = ~brk; rx_break = brk; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0; rx_break = 1'b0;
    endtask

    task automatic pulse_evt(input logic [15:0] e1, input logic [15:0] e2);
        @(negedge clk);
        stat1_evt = e1; stat2_evt = e2;
        @(negedge clk);
        stat1_evt = '0; stat2_evt = '0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
        check("R1 rx_ready", {31'b0, rx_ready}, 32'h1);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data);
            else            rd_check($sformatf("R1/R2 vec%0d", i), VECS[i].addr, VECS[i].exp);
        end
        rd_check("R2 undecoded", 12'h0F0, 32'h0);

        // R3 receive, then blocking while full
        bus_write(12'h080, 32'h0);
        send_rx(1'b0, 8'h5A);
        check("R3 rx_ready low", {31'b0, rx_ready}, 32'h0);
        rd_check("R3 status 1", 12'h094, 32'h6240);
        rd_check("R3 status 2", 12'h098, 32'h4029);
        rd_check("R3 test/status", 12'h0B4, 32'h0040);
        send_rx(1'b0, 8'hC3);
        // R4 consume then stale
        rd_check("R3/R4 consume", 12'h000, 32'h805A);
        rd_check("R4 stale read", 12'h000, 32'h005A);
        rd_check("R4 status 1 after", 12'h094, 32'h6040);
        rd_check("R4 status 2 after", 12'h098, 32'h4028);
        check("R4 rx_ready", {31'b0, rx_ready}, 32'h1);
        // R5 break
        send_rx(1'b1, 8'h00);
        rd_check("R5 break word", 12'h000, 32'h8800);

        // R9 interrupt gating, receive empty, transmitter idle
        bus_write(12'h080, 32'h2000); @(negedge clk);
        check("R9 tx-ready enable alone", {31'b0, irq}, 32'h0);
        bus_write(12'h080, 32'h0040); @(negedge clk);
        check("R9 tx-empty enable", {31'b0, irq}, 32'h1);
        bus_write(12'h080, 32'h2040); @(negedge clk);
        check("R9 both tx enables", {31'b0, irq}, 32'h1);
        bus_write(12'h080, 32'h0200); @(negedge clk);
        check("R9 rx enable, empty", {31'b0, irq}, 32'h0);
        send_rx(1'b0, 8'h11);
        check("R9 rx enable, full", {31'b0, irq}, 32'h1);
        bus_write(12'h080, 32'h0000); @(negedge clk);
        check("R9 rx full, disabled", {31'b0, irq}, 32'h0);
        rd_check("R9 drain", 12'h000, 32'h8011);

        // R8 transmit
        bus_write(12'h040, 32'h0000_0077);
        check("R8 disabled write ignored", {31'b0, tx_valid}, 32'h0);
        bus_write(12'h080, 32'h0040);
        bus_write(12'h084, 32'h0000_0005);
        bus_write(12'h040, 32'h0000_01A7);
        check("R8 tx_valid", {31'b0, tx_valid}, 32'h1);
        check("R8 tx_data", {24'b0, tx_data}, 32'hA7);
        check("R9 irq while pending", {31'b0, irq}, 32'h0);
        rd_check("R8 status 1 pending", 12'h094, 32'h4040);
        rd_check("R8 status 2 pending", 12'h098, 32'h0020);
        rd_check("R8 test/status pending", 12'h0B4, 32'h0020);
        bus_write(12'h040, 32'h0000_0055);
        check("R8 held byte", {24'b0, tx_data}, 32'hA7);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
        check("R8 handshake done", {31'b0, tx_valid}, 32'h0);
        check("R9 irq after send", {31'b0, irq}, 32'h1);
        rd_check("R8 status 1 idle", 12'h094, 32'h6040);

        // R6 / R7 sticky bits
        pulse_evt(16'hFFFF, 16'hFFFF);
        rd_check("R6 status 1 set", 12'h094, 32'hFDF0);
        rd_check("R7 status 2 set", 12'h098, 32'hFDFE);
        bus_write(12'h094, 32'h0000_0030);
        rd_check("R6 partial clear", 12'h094, 32'hFDC0);
        bus_write(12'h094, 32'hFFFF_FFFF);
        rd_check("R6 full clear", 12'h094, 32'h6040);
        bus_write(12'h098, 32'h0000_FFFF);
        rd_check("R7 full clear", 12'h098, 32'h4028);

        // R10 software reset
        bus_write(12'h088, 32'h0000_1234);
        bus_write(12'h080, 32'h0000_2241);
        send_rx(1'b0, 8'h3C);
        bus_write(12'h084, 32'h0000_0006);
        rd_check("R10 control 2", 12'h084, 32'h0007);
        rd_check("R10 control 1", 12'h080, 32'h0000);
        rd_check("R10 control 3", 12'h088, 32'h0700);
        rd_check("R10 baud count", 12'h0AC, 32'h0004);
        rd_check("R10 receive word", 12'h000, 32'h4000);
        rd_check("R10 FIFO kept", 12'h090, 32'hA5A5);
        rd_check("R10 millisecond kept", 12'h0B0, 32'h03E8);
        check("R10 rx_ready", {31'b0, rx_ready}, 32'h1);
        check("R10 irq", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule